// File: doc/BRIEF.md
# Batched DRAM Refresh Scheduler

This block generates the periodic refresh traffic for a DRAM controller. It can also save up several refresh intervals and pay them off together. A free-running interval timer ticks once every `T_REFI` cycles. A batch counter turns every `N_BATCH` ticks into a single request. The block then raises a bus request towards the memory controller and waits for a grant. Once the grant arrives, it issues `N_BATCH` complete refresh sequences back to back and then drops its request. Each sequence is a precharge-all command, a `T_RP` wait, an auto-refresh command and a `T_RFC` wait.

Batching cuts the number of times the controller is interrupted from once per `T_REFI` to once per `N_BATCH*T_REFI`. The total refresh rate stays the same. With `N_BATCH = 1` the block behaves as a plain one-refresh-per-interval scheduler.

Commands leave on a valid/ready channel that carries a two-bit command code. Any command may be stalled by the controller. Both waits are counted from the handshake cycle, so a stall never shortens them.

Top module: `refresh_batcher`

## Requirements
- R1: While enabled, with prompt grant and ready, successive rising edges of `bus_req` are exactly `N_BATCH*T_REFI` cycles apart.
- R2: Directly after reset, `bus_req` and `cmd_valid` are low and `cmd_kind` reads 2'b00 (no command).
- R3: While `refresh_en` is low, `bus_req` and `cmd_valid` stay low. A batch boundary that passes while disabled is dropped and not queued.
- R4: No command is valid before the grant. The first precharge-all becomes valid in the cycle after `bus_gnt` is sampled high, and `cmd_valid` is only ever high while `bus_req` is high.
- R5: Each burst holds exactly `N_BATCH` command pairs, each pair being precharge-all (`cmd_kind` 2'b01) followed by auto-refresh (`cmd_kind` 2'b10).
- R6: A valid command keeps `cmd_valid` high and `cmd_kind` unchanged until the cycle in which `cmd_ready` is high.
- R7: The auto-refresh command becomes valid exactly `T_RP` cycles after the clock edge that accepted the preceding precharge-all.
- R8: Within a burst, the next precharge-all becomes valid exactly `T_RFC` cycles after the clock edge that accepted the preceding auto-refresh.
- R9: `bus_req` stays high from its rise until the last sequence ends. It falls exactly `T_RFC` cycles after the edge that accepted the final auto-refresh.
- R10: The interval timer never pauses. Grant delays, ready stalls and disabled periods do not shift the cycles on which later bursts start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_en | input | 1 | Enables raising refresh requests |
| bus_req | output | 1 | Request for the controller's command bus |
| bus_gnt | input | 1 | Grant of the command bus; held until `bus_req` falls |
| cmd_valid | output | 1 | Command on `cmd_kind` is valid |
| cmd_ready | input | 1 | Controller accepts the current command |
| cmd_kind | output | 2 | 00 none, 01 precharge all, 10 auto refresh |

## Verification
The burst engine is driven with a table of combinations of grant delay and per-command ready stall. It includes a case with no stall at all, a grant-only delay, a ready-only stall and mixed cases. The zero-stall rows pin down the exact `T_RP` and `T_RFC` spacings and the release cycle. The stalled rows show whether the waits count from the handshake or from the cycle in which the command first appeared, and whether a stalled command holds its code. Every burst start is also timed against the previous one. This makes a timer that paused for grant or stall latency visible as drift. A disabled window spanning two batch boundaries shows whether missed requests are dropped or wrongly queued.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

   typedef enum logic [1:0] {
      CMD_NOP  = 2'b00,
      CMD_PREA = 2'b01,
      CMD_AREF = 2'b10
   } cmd_kind_e;

   typedef enum logic [1:0] {
      CT_IDLE,
      CT_WAIT_GNT,
      CT_RUN
   } ctl_state_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_PRE,
      SQ_WRP,
      SQ_REF,
      SQ_WRFC
   } seq_state_e;

endpackage

// File: rtl/rfb_interval_timer.sv
module rfb_interval_timer #(
   parameter int unsigned INTERVAL = 64
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW = $clog2(INTERVAL);

   logic [CW-1:0] cnt;

   assign tick = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt <= CW'(INTERVAL - 1);
      else if (tick)     cnt <= CW'(INTERVAL - 1);
      else               cnt <= cnt - 1'b1;
   end

   // R10: the free-running tick is a single-cycle pulse
   a_r10_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/rfb_batch_accum.sv
module rfb_batch_accum #(
   parameter int unsigned N_BATCH = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic batch_req
);
   generate
      if (N_BATCH == 1) begin : g_pass
         always_ff @(posedge clk) begin
            if (!rst_n) batch_req <= 1'b0;
            else        batch_req <= tick;
         end
      end else begin : g_count
         localparam int unsigned CW = $clog2(N_BATCH);
         logic [CW-1:0] left;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               left      <= CW'(N_BATCH - 1);
               batch_req <= 1'b0;
            end else begin
               batch_req <= 1'b0;
               if (tick) begin
                  if (left == '0) begin
                     left      <= CW'(N_BATCH - 1);
                     batch_req <= 1'b1;
                  end else begin
                     left <= left - 1'b1;
                  end
               end
            end
         end
      end
   endgenerate

   // R1: one batch request per batch boundary, never two in a row
   a_r1_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      batch_req |=> !batch_req);

endmodule

// File: rtl/rfb_seq_engine.sv
module rfb_seq_engine
   import rfb_pkg::*;
#(
   parameter int unsigned T_RP    = 3,
   parameter int unsigned T_RFC   = 10,
   parameter int unsigned N_BATCH = 1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   output logic      cmd_valid,
   input  logic      cmd_ready,
   output cmd_kind_e cmd_kind,
   output logic      all_done
);
   localparam int unsigned TMAX = (T_RP > T_RFC) ? T_RP : T_RFC;
   localparam int unsigned WW   = $clog2(TMAX);

   seq_state_e    st;
   logic [WW-1:0] wcnt;
   logic          wait_end;
   logic          seq_end;
   logic          chain_zero;

   assign wait_end = (wcnt == '0);
   assign seq_end  = (st == SQ_WRFC) && wait_end;
   assign all_done = seq_end && chain_zero;

   // remaining sequences after the current one
   generate
      if (N_BATCH == 1) begin : g_single
         assign chain_zero = 1'b1;
      end else begin : g_chain
         localparam int unsigned CCW = $clog2(N_BATCH);
         logic [CCW-1:0] chain;

         assign chain_zero = (chain == '0);

         always_ff @(posedge clk) begin
            if (!rst_n)                      chain <= '0;
            else if (start)                  chain <= CCW'(N_BATCH - 1);
            else if (seq_end && !chain_zero) chain <= chain - 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= SQ_IDLE;
         wcnt <= '0;
      end else begin
         unique case (st)
            SQ_IDLE: if (start) st <= SQ_PRE;
            SQ_PRE: if (cmd_ready) begin
               st   <= SQ_WRP;
               wcnt <= WW'(T_RP - 2);
            end
            SQ_WRP: begin
               if (wait_end) st   <= SQ_REF;
               else          wcnt <= wcnt - 1'b1;
            end
            SQ_REF: if (cmd_ready) begin
               st   <= SQ_WRFC;
               wcnt <= WW'(T_RFC - 2);
            end
            SQ_WRFC: begin
               if (wait_end) st   <= chain_zero ? SQ_IDLE : SQ_PRE;
               else          wcnt <= wcnt - 1'b1;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      cmd_valid = 1'b0;
      cmd_kind  = CMD_NOP;
      if (st == SQ_PRE) begin
         cmd_valid = 1'b1;
         cmd_kind  = CMD_PREA;
      end else if (st == SQ_REF) begin
         cmd_valid = 1'b1;
         cmd_kind  = CMD_AREF;
      end
   end

   // R6: a stalled command stays valid with the same code
   a_r6_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind)));

   // R5: only the two refresh command codes are ever presented
   a_r5_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_kind == CMD_PREA || cmd_kind == CMD_AREF));

   // R4: a new burst is only started while no command is outstanding
   a_r4_start_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !cmd_valid);

endmodule

// File: rtl/refresh_batcher.sv
module refresh_batcher
   import rfb_pkg::*;
#(
   parameter int unsigned T_REFI  = 64,
   parameter int unsigned T_RP    = 3,
   parameter int unsigned T_RFC   = 10,
   parameter int unsigned N_BATCH = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       refresh_en,
   output logic       bus_req,
   input  logic       bus_gnt,
   output logic       cmd_valid,
   input  logic       cmd_ready,
   output logic [1:0] cmd_kind
);
   generate
      if (T_RP < 2) begin : g_bad_rp
         $error("T_RP must be at least 2");
      end
      if (T_RFC < 2) begin : g_bad_rfc
         $error("T_RFC must be at least 2");
      end
      if (N_BATCH < 1) begin : g_bad_n
         $error("N_BATCH must be at least 1");
      end
      if (T_REFI <= T_RP + T_RFC) begin : g_bad_refi
         $error("T_REFI must exceed T_RP + T_RFC");
      end
   endgenerate

   ctl_state_e st;
   logic       tick;
   logic       batch_req;
   logic       start;
   logic       seq_done;
   cmd_kind_e  kind_e;

   rfb_interval_timer #(.INTERVAL(T_REFI)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   rfb_batch_accum #(.N_BATCH(N_BATCH)) u_accum (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .batch_req (batch_req)
   );

   rfb_seq_engine #(.T_RP(T_RP), .T_RFC(T_RFC), .N_BATCH(N_BATCH)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready),
      .cmd_kind  (kind_e),
      .all_done  (seq_done)
   );

   assign cmd_kind = kind_e;
   assign start    = (st == CT_WAIT_GNT) && bus_gnt;
   assign bus_req  = (st != CT_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= CT_IDLE;
      end else begin
         unique case (st)
            CT_IDLE:     if (batch_req && refresh_en) st <= CT_WAIT_GNT;
            CT_WAIT_GNT: if (bus_gnt)                 st <= CT_RUN;
            CT_RUN:      if (seq_done)                st <= CT_IDLE;
            default:                                  st <= CT_IDLE;
         endcase
      end
   end

   // R4: commands appear only while the bus is requested
   a_r4_valid_in_request: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> bus_req);

   // R3: no request is raised while refresh is disabled
   a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_req && !refresh_en) |=> !bus_req);

   // R9: the request is held until the last sequence has finished
   a_r9_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !seq_done) |=> bus_req);

endmodule

// File: tb/refresh_batcher_tb.sv
module refresh_batcher_tb;
   localparam int P_REFI = 40;
   localparam int P_RP   = 3;
   localparam int P_RFC  = 7;
   localparam int P_N    = 4;
   localparam int PERIOD = P_N * P_REFI;

   // stimulus table: grant delay and per-command ready stall
   localparam int NVEC = 6;
   localparam int GNT_DLY [NVEC] = '{0, 2, 0, 3, 1, 0};
   localparam int RDY_DLY [NVEC] = '{0, 0, 1, 2, 3, 0};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       refresh_en = 1'b1;
   logic       bus_req;
   logic       bus_gnt = 1'b0;
   logic       cmd_valid;
   logic       cmd_ready = 1'b0;
   logic [1:0] cmd_kind;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int last_rise = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   refresh_batcher #(
      .T_REFI(P_REFI), .T_RP(P_RP), .T_RFC(P_RFC), .N_BATCH(P_N)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .refresh_en(refresh_en),
      .bus_req(bus_req), .bus_gnt(bus_gnt),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // one burst: wait for request, grant after gd cycles, stall each command rd cycles
   task automatic run_burst(input int gd, input int rd, input int mult, input bit first);
      int  t;
      int  k;
      bit  early;
      bit  hold_bad;
      bit  req_bad;
      int  exp_kind;
      int  exp_gap;
      early = 0; hold_bad = 0; req_bad = 0;
      t = 0;
      while (!bus_req && t < 4 * PERIOD) begin
         if (cmd_valid) early = 1;
         @(negedge clk); t++;
      end
      chk(bus_req == 1'b1, "R1 request raised", bus_req, 1);
      if (!first)
         chk(cyc - last_rise == mult * PERIOD, "R1/R10 burst spacing",
             cyc - last_rise, mult * PERIOD);
      last_rise = cyc;
      repeat (gd) begin
         if (cmd_valid) early = 1;
         @(negedge clk);
      end
      chk(!early && !cmd_valid, "R4 no command before grant", early, 0);
      bus_gnt = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 2 * P_N; i++) begin
         exp_kind = (i % 2 == 0) ? 1 : 2;
         if (i == 0) begin
            chk(cmd_valid == 1'b1, "R4 first precharge after grant", cmd_valid, 1);
         end else begin
            exp_gap = (i % 2 == 1) ? P_RP : P_RFC;
            k = 1;
            while (!cmd_valid && k < 100) begin
               if (!bus_req) req_bad = 1;
               @(negedge clk); k++;
            end
            if (i % 2 == 1) chk(k == exp_gap, "R7 precharge to refresh", k, exp_gap);
            else            chk(k == exp_gap, "R8 refresh to precharge", k, exp_gap);
         end
         chk(int'(cmd_kind) == exp_kind, "R5 command order", cmd_kind, exp_kind);
         repeat (rd) begin
            @(negedge clk);
            if (!cmd_valid || int'(cmd_kind) != exp_kind) hold_bad = 1;
         end
         cmd_ready = 1'b1;
         @(negedge clk);
         cmd_ready = 1'b0;
      end
      chk(!hold_bad, "R6 stalled command held", hold_bad, 0);
      k = 1;
      early = 0;
      while (bus_req && k < 100) begin
         if (cmd_valid) early = 1;
         @(negedge clk); k++;
      end
      chk(k == P_RFC, "R9 release after last refresh", k, P_RFC);
      chk(!early && !req_bad, "R5/R9 no extra command, request held", early, 0);
      bus_gnt = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(bus_req == 1'b0, "R2 reset bus_req", bus_req, 0);
      chk(cmd_valid == 1'b0, "R2 reset cmd_valid", cmd_valid, 0);
      chk(cmd_kind == 2'b00, "R2 reset cmd_kind", cmd_kind, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_req == 1'b0 && cmd_valid == 1'b0, "R2 idle after reset", bus_req, 0);

      // table-driven bursts
      for (int v = 0; v < NVEC; v++)
         run_burst(GNT_DLY[v], RDY_DLY[v], 1, v == 0);

      // R3: two batch boundaries pass while disabled and are dropped
      begin
         bit seen;
         seen = 0;
         refresh_en = 1'b0;
         repeat (2 * PERIOD + 10) begin
            @(negedge clk);
            if (bus_req || cmd_valid) seen = 1;
         end
         chk(!seen, "R3 quiet while disabled", seen, 0);
         refresh_en = 1'b1;
      end
      run_burst(0, 0, 3, 1'b0);

      // R10: long grant delay does not shift the following burst
      run_burst(20, 1, 1, 1'b0);
      run_burst(0, 0, 1, 1'b0);
      finish_up();
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_up();
   end

endmodule